// File: doc/BRIEF.md
# Fixed-Slot SDRAM Access and Refresh Scheduler

This block drives a single-data-rate SDRAM from a slow system clock. Time is cut into slots of nine clock cycles. Each slot can carry at most one single-word read or write, and that access always closes with auto-precharge. Every slot then issues exactly one auto-refresh. Because a refresh arrives at a fixed period, the memory keeps its contents at any clock rate fast enough for one slot to fit within the per-row refresh interval of 15.625 us (4096 rows in 64 ms). At such low clock rates, refreshing only when the bus is idle could not be trusted. No refresh is issued beyond the one per slot, which keeps refresh power and heat bounded.

A host presents a bank, row, column, a direction bit and a write word with a valid/ready handshake. Ready is raised only on the first cycle of a slot. A request that arrives later in a slot is held until the next slot begins. Read data comes back on a one-cycle strobe at a fixed offset inside the slot. After reset the block runs the memory's power-up sequence itself, and it accepts requests only once that sequence is done.

Top module: `sdr_slot_sched`

## Requirements
- R1: After reset the command pins show NOP for at least PWRUP_CYC cycles. The block then issues, in this order and with NOPs between them: precharge-all (address bit 10 = 1), auto-refresh, auto-refresh, and a mode-register load with bank 0 and address 0x020 (burst length 1, sequential, CAS latency 2). Only after this does `init_done` rise. `req_ready` stays low while `init_done` is low.
- R2: Commands use the encoding {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE LOAD 0000.
- R3: Once `init_done` is high, slots are 9 cycles long, numbered 0..8, with slot 0 being the first cycle with `init_done` high. `req_ready` is high on slot cycle 0 and on no other cycle.
- R4: Exactly one REFRESH is issued per slot, on slot cycle 7. Consecutive refreshes after initialisation are exactly 9 cycles apart.
- R5: A request taken on slot cycle 0 produces ACTIVATE on cycle 1 with the request's bank and row. It produces READ or WRITE on cycle 3 with the same bank, the column on the low address bits and address bit 10 = 1 (auto-precharge).
- R6: `sd_dq_oe` is high only on the WRITE cycle of a write slot, and `sd_dq_out` then equals the request's write word.
- R7: For a read, `sd_dq_in` is sampled at the end of slot cycle 5 (CAS latency 2 after READ). `rd_valid` is high for exactly one cycle, slot cycle 6, with that word on `rd_data`.
- R8: A slot with no accepted request shows NOP on every cycle except the cycle 7 REFRESH, and it drives no data.
- R9: A request raised on slot cycle k is taken on the next slot cycle 0, which is (9-k) mod 9 cycles later.
- R10: The time between refreshes never exceeds 15.625 us at the configured clock. A configuration whose 9-cycle slot does not fit in that interval fails at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | High on slot cycle 0 once initialised |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DATA_W | Word to write |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read word |
| init_done | output | 1 | Power-up sequence complete |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dq_out | output | DATA_W | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Read data from memory |

## Verification
The hardest cases to reach from the ports are a request that arrives partway through a slot and a read that follows a write to the same address in the very next slot. In both, the result depends on the exact slot cycle at which the request appears. The stimulus therefore inserts random idle gaps before each request, and these land requests on every slot cycle. It also repeats a few addresses so that a read often targets an address just written. The memory model returns read data only in the single cycle that CAS latency allows, with a marker word at all other times. A capture taken one cycle early or late therefore gives a visible wrong word. A long idle stretch shows that slots with no work keep refreshing on their fixed cadence.

// File: rtl/sdr_slot_pkg.sv
package sdr_slot_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  localparam int unsigned SLOT_LEN = 9;
  localparam int unsigned PH_ACT   = 1;
  localparam int unsigned PH_RW    = 3;
  localparam int unsigned PH_CAP   = 5;
  localparam int unsigned PH_REF   = 7;
  localparam int unsigned CAS_LAT  = 2;
  localparam int unsigned AP_BIT   = 10;

  // mode word: burst length 1, sequential, CAS latency in bits 6:4
  function automatic logic [31:0] mode_word(int unsigned cl);
    return 32'(cl) << 4;
  endfunction

  // a slot of n cycles fits the refresh interval when n*1e6/clk_khz <= ref_ns
  function automatic bit slot_fits(longint unsigned clk_khz,
                                   longint unsigned ref_ns,
                                   int unsigned n);
    return (longint'(n) * 64'd1_000_000) <= (ref_ns * clk_khz);
  endfunction

endpackage

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_slot_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 25000
) (
  input  logic     clk,
  input  logic     rst_n,
  output sdr_cmd_e cmd,
  output logic     done
);
  localparam int unsigned CW    = $clog2(PWRUP_CYC + 1);
  localparam int unsigned NSTEP = 9;

  logic [CW-1:0] wait_q;
  logic          waiting_q;
  logic [3:0]    step_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q    <= '0;
      waiting_q <= 1'b1;
      step_q    <= '0;
      done_q    <= 1'b0;
    end else if (waiting_q) begin
      if (wait_q == CW'(PWRUP_CYC - 1)) waiting_q <= 1'b0;
      else                              wait_q    <= wait_q + 1'b1;
    end else if (!done_q) begin
      if (step_q == 4'(NSTEP - 1)) done_q <= 1'b1;
      else                         step_q <= step_q + 1'b1;
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (!waiting_q && !done_q) begin
      case (step_q)
        4'd0:    cmd = CMD_PRE;
        4'd2:    cmd = CMD_REF;
        4'd4:    cmd = CMD_REF;
        4'd6:    cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign done = done_q;

  // R1: the mode load is the last command before done rises
  a_r1_done_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !waiting_q);
endmodule

// File: rtl/sdr_slot_engine.sv
module sdr_slot_engine
  import sdr_slot_pkg::*;
#(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output sdr_cmd_e          cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int unsigned PH_W = $clog2(SLOT_LEN);

  logic [PH_W-1:0]   ph_q;
  logic              busy_q, we_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q, rd_data_q;
  logic              rd_valid_q;

  // named slot events
  logic take, ev_act, ev_rw, ev_read, ev_ref, ev_cap;

  assign req_ready = en && (ph_q == '0);
  assign take      = req_valid && req_ready;
  assign ev_act    = busy_q && (ph_q == PH_W'(PH_ACT));
  assign ev_rw     = busy_q && (ph_q == PH_W'(PH_RW));
  assign ev_read   = ev_rw && !we_q;
  assign ev_cap    = busy_q && !we_q && (ph_q == PH_W'(PH_CAP));
  assign ev_ref    = en && (ph_q == PH_W'(PH_REF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= '0;
      busy_q     <= 1'b0;
      we_q       <= 1'b0;
      bank_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wdata_q    <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (en) ph_q <= (ph_q == PH_W'(SLOT_LEN - 1)) ? '0 : ph_q + 1'b1;
      if (req_ready) begin
        busy_q <= take;
        if (take) begin
          we_q    <= req_we;
          bank_q  <= req_bank;
          row_q   <= req_row;
          col_q   <= req_col;
          wdata_q <= req_wdata;
        end
      end
      rd_valid_q <= ev_cap;
      if (ev_cap) rd_data_q <= dq_in;
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (ev_act) begin
      cmd  = CMD_ACT;
      ba   = bank_q;
      addr = row_q;
    end else if (ev_rw) begin
      cmd  = we_q ? CMD_WR : CMD_RD;
      ba   = bank_q;
      addr[COL_W-1:0] = col_q;
      addr[AP_BIT]    = 1'b1;
    end else if (ev_ref) begin
      cmd = CMD_REF;
    end
  end

  assign dq_oe    = ev_rw && we_q;
  assign dq_out   = wdata_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R3: ready lasts a single cycle per slot
  a_r3_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R4: refresh falls seven cycles after the slot's ready cycle
  a_r4_ref_slot_pos: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref |-> $past(req_ready, 7));
  // R5: column command two cycles after activate
  a_r5_rw_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rw |-> $past(ev_act, 2));
  // R7: read strobe three cycles after READ, one cycle wide
  a_r7_rdv_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(ev_read, 3));
  a_r7_rdv_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |=> !rd_valid_q);
endmodule

// File: rtl/sdr_slot_sched.sv
module sdr_slot_sched
  import sdr_slot_pkg::*;
#(
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned REF_NS    = 15625,
  parameter int unsigned PWRUP_CYC = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam bit FITS = slot_fits(64'(CLK_KHZ), 64'(REF_NS), SLOT_LEN);

  generate
    if (!FITS) begin : g_slot_too_long
      $error("slot of %0d cycles exceeds the refresh interval", SLOT_LEN);
    end
    if (ROW_W <= AP_BIT || COL_W > AP_BIT) begin : g_bad_widths
      $error("address widths leave no room for the auto-precharge bit");
    end
  endgenerate

  sdr_cmd_e          ini_cmd, eng_cmd, cmd;
  logic [BANK_W-1:0] eng_ba;
  logic [ROW_W-1:0]  eng_addr;
  logic              cke_q;

  sdr_init_seq #(.PWRUP_CYC(PWRUP_CYC)) u_init (
    .clk(clk), .rst_n(rst_n), .cmd(ini_cmd), .done(init_done)
  );

  sdr_slot_engine #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .en(init_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .cmd(eng_cmd), .ba(eng_ba), .addr(eng_addr),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .dq_in(sd_dq_in)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= 1'b1;
  end
  assign sd_cke = cke_q;

  always_comb begin
    if (init_done) begin
      cmd     = eng_cmd;
      sd_ba   = eng_ba;
      sd_addr = eng_addr;
    end else begin
      cmd     = ini_cmd;
      sd_ba   = '0;
      sd_addr = '0;
      if (ini_cmd == CMD_MRS)      sd_addr = ROW_W'(mode_word(CAS_LAT));
      else if (ini_cmd == CMD_PRE) sd_addr[AP_BIT] = 1'b1;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // R1: no request accepted before initialisation completes
  a_r1_no_ready_early: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  // R6: data bus driven only alongside a WRITE on the pins
  a_r6_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100));
endmodule

// File: tb/sdr_slot_sched_tb.sv
module sdr_slot_sched_tb_top;
  localparam int ROW_W = 12, COL_W = 8, BANK_W = 2, DATA_W = 16;
  localparam int PWRUP = 40;
  localparam int SLOT = 9;
  localparam int PERIOD_NS = 8;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0, sd_dq_in = '0;
  logic req_ready, rd_valid, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DATA_W-1:0] rd_data, sd_dq_out;
  logic [BANK_W-1:0] sd_ba;
  logic [ROW_W-1:0]  sd_addr;

  always #4 clk = ~clk;

  sdr_slot_sched #(.PWRUP_CYC(PWRUP)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] init_pat(int key);
    return key[15:0] ^ 16'hA5C3;
  endfunction
  function automatic int mkey(logic [1:0] b, logic [11:0] r, logic [7:0] c);
    return int'({b, r, c});
  endfunction

  logic [15:0] exp_mem [int];
  logic [15:0] dev_mem [int];

  // monitor state
  wire [3:0] pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  int  nop_lead = 0, nseq = 0, t0 = -1, last_ref = -1, rd_cyc = -100;
  logic [3:0]  seq_c [4];
  logic [11:0] seq_a [4];
  logic [1:0]  seq_b [4];
  bit  seen_cmd = 0, early_ready = 0;
  bit  acc = 0, acc_we = 0;
  logic [1:0] acc_b; logic [11:0] acc_r; logic [7:0] acc_c; logic [15:0] acc_d, acc_exp;
  int  v_rise = -1, v_rise_s = 0, mid_hits = 0;
  bit  bank_open [4];
  logic [11:0] open_row [4];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (!init_done) begin
        if (req_ready) early_ready = 1;
        if (pc != C_NOP) begin
          seen_cmd = 1;
          if (nseq < 4) begin seq_c[nseq] = pc; seq_a[nseq] = sd_addr; seq_b[nseq] = sd_ba; end
          nseq++;
        end else if (!seen_cmd) nop_lead++;
      end else begin
        int s;
        if (t0 < 0) begin
          t0 = cyc;
          chk(nop_lead >= PWRUP, "R1", "leading NOP cycles", nop_lead, PWRUP);
          chk(nseq == 4, "R1", "init command count", nseq, 4);
          chk(seq_c[0] == C_PRE && seq_a[0][10], "R1", "precharge-all", seq_c[0], C_PRE);
          chk(seq_c[1] == C_REF && seq_c[2] == C_REF, "R1", "two refreshes",
              {seq_c[1], seq_c[2]}, {C_REF, C_REF});
          chk(seq_c[3] == C_MRS && seq_a[3] == 12'h020 && seq_b[3] == 0, "R1", "mode load word",
              seq_a[3], 12'h020);
          chk(!early_ready, "R1", "ready before init_done", early_ready, 0);
          chk(sd_cke, "R1", "cke high", sd_cke, 1);
        end
        s = (cyc - t0) % SLOT;
        if (s == 0) acc = 0;
        // R3: ready only on slot cycle 0
        chk(req_ready == (s == 0), "R3", "ready position", req_ready, s == 0);
        // R9 tracking of mid-slot arrival
        if (req_valid && v_rise < 0) begin v_rise = cyc; v_rise_s = s; end
        if (req_valid && req_ready) begin
          chk(cyc - v_rise == (SLOT - v_rise_s) % SLOT, "R9", "wait to next slot",
              cyc - v_rise, (SLOT - v_rise_s) % SLOT);
          if (v_rise_s != 0) mid_hits++;
          v_rise = -1;
          acc = 1; acc_we = req_we; acc_b = req_bank; acc_r = req_row; acc_c = req_col;
          acc_d = req_wdata;
          if (req_we) begin exp_mem[mkey(req_bank, req_row, req_col)] = req_wdata; acc_exp = req_wdata; end
          else acc_exp = exp_mem.exists(mkey(req_bank, req_row, req_col)) ?
                         exp_mem[mkey(req_bank, req_row, req_col)] : init_pat(mkey(req_bank, req_row, req_col));
        end
        // R2/R4/R5/R8: expected command at this slot cycle
        begin
          logic [3:0] ec; logic [11:0] ea; logic [1:0] eb;
          ec = C_NOP; ea = 0; eb = 0;
          if (s == 7) ec = C_REF;
          else if (acc && s == 1) begin ec = C_ACT; ea = acc_r; eb = acc_b; end
          else if (acc && s == 3) begin ec = acc_we ? C_WR : C_RD; ea = {3'b0, 1'b1, 2'b0, acc_c} ; eb = acc_b; end
          chk(pc == ec, acc ? "R5" : "R8", "command", pc, ec);
          if (ec != C_NOP && ec != C_REF)
            chk(sd_addr == ea && sd_ba == eb, "R5", "address/bank", {sd_ba, sd_addr}, {eb, ea});
        end
        // R4/R10: refresh spacing
        if (pc == C_REF) begin
          if (last_ref > 0) begin
            chk(cyc - last_ref == SLOT, "R4", "refresh spacing", cyc - last_ref, SLOT);
            chk((cyc - last_ref) * PERIOD_NS <= 15625, "R10", "refresh interval ns",
                (cyc - last_ref) * PERIOD_NS, 15625);
          end
          last_ref = cyc;
        end
        // R6: data drive
        chk(sd_dq_oe == (acc && acc_we && s == 3), "R6", "dq_oe", sd_dq_oe, acc && acc_we && s == 3);
        if (sd_dq_oe) chk(sd_dq_out == acc_d, "R6", "write word", sd_dq_out, acc_d);
        // R7: read strobe and data
        chk(rd_valid == (acc && !acc_we && s == 6), "R7", "rd_valid position", rd_valid,
            acc && !acc_we && s == 6);
        if (rd_valid) chk(rd_data == acc_exp, "R7", "read word", rd_data, acc_exp);
      end
      // memory model with protocol checks
      case (pc)
        C_ACT: begin
          chk(!bank_open[sd_ba], "R5", "activate to open bank", bank_open[sd_ba], 0);
          bank_open[sd_ba] = 1; open_row[sd_ba] = sd_addr;
        end
        C_RD, C_WR: begin
          int k;
          chk(bank_open[sd_ba], "R5", "column cmd to closed bank", bank_open[sd_ba], 1);
          k = mkey(sd_ba, open_row[sd_ba], sd_addr[7:0]);
          if (pc == C_WR) dev_mem[k] = sd_dq_out;
          else begin rd_cyc = cyc; acc_d = dev_mem.exists(k) ? dev_mem[k] : init_pat(k); end
          if (sd_addr[10]) bank_open[sd_ba] = 0;
        end
        C_REF: chk(!(bank_open[0] | bank_open[1] | bank_open[2] | bank_open[3]),
                   "R4", "refresh with open bank", 1, 0);
        C_PRE: for (int b = 0; b < 4; b++) bank_open[b] = 0;
        default: ;
      endcase
      // read data valid only CAS latency after READ
      sd_dq_in = (cyc == rd_cyc + 2) ? acc_d : 16'hBEEF ^ cyc[15:0];
    end
  end

  task automatic send(bit we, logic [1:0] b, logic [11:0] r, logic [7:0] c, logic [15:0] d, int gap);
    bit hs;
    repeat (gap) @(posedge clk);
    #1;
    req_valid = 1; req_we = we; req_bank = b; req_row = r; req_col = c; req_wdata = d;
    do begin @(negedge clk); hs = req_ready; end while (!hs);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      finished = 1;
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!init_done && !req_ready && !rd_valid && !sd_dq_oe, "R1", "reset outputs",
        {init_done, req_ready, rd_valid, sd_dq_oe}, 0);
    chk(pc == C_NOP && !sd_cke, "R2", "reset command NOP", {sd_cke, pc}, C_NOP);
    @(posedge clk); #1 rst_n = 1;
    // request raised during init must wait
    req_valid = 1; req_we = 0;
    wait (init_done);
    @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    // directed corners: top row, top column, back-to-back write/read
    send(1, 2'd3, 12'hFFF, 8'hFF, 16'h1234, 0);
    send(0, 2'd3, 12'hFFF, 8'hFF, 16'h0, 0);
    send(1, 2'd0, 12'h000, 8'h00, 16'hFFFF, 3);
    send(0, 2'd0, 12'h000, 8'h00, 16'h0, 5);
    send(0, 2'd1, 12'h7A5, 8'h3C, 16'h0, 8);
    // idle stretch: only refreshes must appear
    repeat (45) @(posedge clk);
    for (int i = 0; i < 400; i++) begin
      logic [11:0] r;
      r = ($urandom % 4 == 0) ? 12'hFFF : 12'($urandom % 3);
      send($urandom % 2 == 1, 2'($urandom), r, 8'($urandom % 6), 16'($urandom), $urandom % 12);
    end
    repeat (20) @(posedge clk);
    chk(mid_hits > 10, "R9", "mid-slot arrivals exercised", mid_hits, 10);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule